// File: doc/BRIEF.md
# Chip-Select Gated Address/Command Register

This block is the clocked register that sits between a memory controller and the devices on a memory module. On every rising clock edge it captures an address/command word and drives it out again. The gated data lanes load only while at least one of the two active-low select inputs is low. When both selects are high, those lanes keep their previous value. The registered select bit and the on-die-termination and clock-enable bits load on every edge, whatever the select levels.

Two static mode pins choose one of three configurations:
- **Wide:** a 23-bit gated data word plus the three ungated bits, one-to-one onto bank A.
- **Narrow, layout A:** an 11-bit gated word taken from one input slice.
- **Narrow, layout B:** the same as layout A, but the 11-bit word comes from the other input slice.

In both narrow layouts each registered bit drives the same position on bank A and on bank B. An asynchronous active-low reset clears every register at once. The internal release of that reset is synchronised to the clock.

There is no handshake at either edge. Every edge is a transfer, there is no back-pressure, and the consumer must accept a new word on every cycle.

Top module: `csrb_regbuf`

## Requirements
- R1: While `rst_n` is low, every output is 0, including `cs_a_n` and `cs_b_n`. The outputs go to 0 without waiting for a clock edge.
- R2: After `rst_n` rises, the first two rising edges capture nothing. The third rising edge is the first one that loads inputs.
- R3: When `dcs_n` and `csr_n` are both 1 at an edge, the gated data outputs `q_a` and `q_b` keep their values.
- R4: When either `dcs_n` or `csr_n` is 0 at an edge, the gated data outputs load the selected input word, one cycle after capture. With `csr_n` held at 0, they load on every edge.
- R5: `odt_a` and `cke_a` take `odt_in` and `cke_in` on every edge, whatever the select levels. In narrow mode, `odt_b` and `cke_b` do the same.
- R6: `cs_a_n` takes `dcs_n` on every edge, whatever `csr_n` is. In narrow mode, `cs_b_n` does the same.
- R7: In wide mode (`mode_dup`=0, `mode_alt`=0), `q_a` equals `din[22:0]` as captured. `q_b`, `cs_b_n`, `odt_b` and `cke_b` are 0.
- R8: In narrow layout A (`mode_dup`=1, `mode_alt`=0), `q_a[10:0]` and `q_b[10:0]` both carry captured `din[10:0]`. Bits 22:11 of both banks are 0. The select, termination and clock-enable bits appear on both banks.
- R9: In narrow layout B (`mode_dup`=1, `mode_alt`=1), both banks carry captured `din[21:11]` in bits 10:0. Bits 22:11 of both banks are 0.
- R10: The combination `mode_alt`=1 with `mode_dup`=0 behaves exactly like wide mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_dup | input | 1 | 1 = narrow word duplicated onto both banks |
| mode_alt | input | 1 | Narrow-mode input slice: 0 = layout A, 1 = layout B |
| dcs_n | input | 1 | Primary select, active low |
| csr_n | input | 1 | Secondary select, active low |
| din | input | 23 | Gated data word |
| odt_in | input | 1 | Termination control bit |
| cke_in | input | 1 | Clock-enable bit |
| q_a | output | 23 | Bank A gated data |
| q_b | output | 23 | Bank B gated data |
| cs_a_n | output | 1 | Bank A registered select |
| cs_b_n | output | 1 | Bank B registered select |
| odt_a | output | 1 | Bank A termination bit |
| odt_b | output | 1 | Bank B termination bit |
| cke_a | output | 1 | Bank A clock-enable bit |
| cke_b | output | 1 | Bank B clock-enable bit |

## Verification
A stuck or wrong load enable shows up at the first edge where the select levels disagree with it. The gated lanes then either freeze or move one cycle later, and the per-clock model catches that on the next cycle. A wrong lane choice or a broken bank duplication appears on the very first loaded word of that mode. A reset synchroniser of the wrong length moves the first loaded word earlier or later by whole cycles, which the release-window checks observe.

// File: rtl/csrb_pkg.sv
package csrb_pkg;

  typedef enum logic [1:0] {
    CFG_WIDE     = 2'd0,
    CFG_NARROW_A = 2'd1,
    CFG_NARROW_B = 2'd2
  } cfg_e;

  // Illegal pin pair (alt without dup) folds onto the wide configuration.
  function automatic cfg_e decode_cfg(input logic dup, input logic alt);
    if (!dup)     return CFG_WIDE;
    else if (alt) return CFG_NARROW_B;
    else          return CFG_NARROW_A;
  endfunction

endpackage

// File: rtl/csrb_rst_sync.sv
module csrb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_out_n
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) chain_q[s] <= 1'b0;
          else         chain_q[s] <= 1'b1;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) chain_q[s] <= 1'b0;
          else         chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign rst_out_n = chain_q[STAGES-1];

endmodule

// File: rtl/csrb_mode_dec.sv
module csrb_mode_dec
  import csrb_pkg::*;
#(
  parameter int DATA_W   = 23,
  parameter int NARROW_W = 11
) (
  input  logic              mode_dup,
  input  logic              mode_alt,
  input  logic [DATA_W-1:0] din,
  output logic              dup_en,
  output logic [DATA_W-1:0] word_d
);

  localparam int PAD_W = DATA_W - NARROW_W;

  cfg_e cfg;

  always_comb begin
    cfg    = decode_cfg(mode_dup, mode_alt);
    dup_en = (cfg != CFG_WIDE);
    unique case (cfg)
      CFG_NARROW_A: word_d = {{PAD_W{1'b0}}, din[NARROW_W-1:0]};
      CFG_NARROW_B: word_d = {{PAD_W{1'b0}}, din[2*NARROW_W-1:NARROW_W]};
      default:      word_d = din;
    endcase
  end

endmodule

// File: rtl/csrb_capture.sv
module csrb_capture #(
  parameter int DATA_W = 23
) (
  input  logic              clk,
  input  logic              rst_n_i,
  input  logic              dcs_n,
  input  logic              csr_n,
  input  logic              odt_in,
  input  logic              cke_in,
  input  logic [DATA_W-1:0] word_d,
  output logic [DATA_W-1:0] word_q,
  output logic              cs_q,
  output logic              odt_q,
  output logic              cke_q
);

  logic load_en;
  assign load_en = ~(dcs_n & csr_n);

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      word_q <= '0;
      cs_q   <= 1'b0;
      odt_q  <= 1'b0;
      cke_q  <= 1'b0;
    end else begin
      cs_q  <= dcs_n;
      odt_q <= odt_in;
      cke_q <= cke_in;
      if (load_en) word_q <= word_d;
    end
  end

  // R3
  hold_when_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    ($past(rst_n_i) && $past(dcs_n) && $past(csr_n)) |-> (word_q == $past(word_q)));

  // R4
  load_when_selected_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    ($past(rst_n_i) && !($past(dcs_n) && $past(csr_n))) |-> (word_q == $past(word_d)));

  // R5
  ctrl_bits_follow_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    $past(rst_n_i) |-> (odt_q == $past(odt_in) && cke_q == $past(cke_in)));

endmodule

// File: rtl/csrb_fanout.sv
module csrb_fanout #(
  parameter int DATA_W = 23,
  parameter int BANKS  = 2
) (
  input  logic              dup_en,
  input  logic [DATA_W-1:0] word_q,
  input  logic              cs_q,
  input  logic              odt_q,
  input  logic              cke_q,
  output logic [DATA_W-1:0] bank_data [BANKS],
  output logic [BANKS-1:0]  bank_cs,
  output logic [BANKS-1:0]  bank_odt,
  output logic [BANKS-1:0]  bank_cke
);

  generate
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
      logic en;
      if (b == 0) begin : g_primary
        assign en = 1'b1;
      end else begin : g_copy
        assign en = dup_en;
      end
      assign bank_data[b] = en ? word_q : '0;
      assign bank_cs[b]   = en & cs_q;
      assign bank_odt[b]  = en & odt_q;
      assign bank_cke[b]  = en & cke_q;
    end
  endgenerate

endmodule

// File: rtl/csrb_regbuf.sv
module csrb_regbuf #(
  parameter int DATA_W      = 23,
  parameter int NARROW_W    = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_dup,
  input  logic              mode_alt,
  input  logic              dcs_n,
  input  logic              csr_n,
  input  logic [DATA_W-1:0] din,
  input  logic              odt_in,
  input  logic              cke_in,
  output logic [DATA_W-1:0] q_a,
  output logic [DATA_W-1:0] q_b,
  output logic              cs_a_n,
  output logic              cs_b_n,
  output logic              odt_a,
  output logic              odt_b,
  output logic              cke_a,
  output logic              cke_b
);

  localparam int BANKS = 2;

  logic              rst_int_n;
  logic              dup_en;
  logic [DATA_W-1:0] word_d;
  logic [DATA_W-1:0] word_q;
  logic              cs_q, odt_q, cke_q;
  logic [DATA_W-1:0] bank_data [BANKS];
  logic [BANKS-1:0]  bank_cs, bank_odt, bank_cke;

  csrb_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk       (clk),
    .arst_n    (rst_n),
    .rst_out_n (rst_int_n)
  );

  csrb_mode_dec #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_dec (
    .mode_dup (mode_dup),
    .mode_alt (mode_alt),
    .din      (din),
    .dup_en   (dup_en),
    .word_d   (word_d)
  );

  csrb_capture #(.DATA_W(DATA_W)) u_cap (
    .clk     (clk),
    .rst_n_i (rst_int_n),
    .dcs_n   (dcs_n),
    .csr_n   (csr_n),
    .odt_in  (odt_in),
    .cke_in  (cke_in),
    .word_d  (word_d),
    .word_q  (word_q),
    .cs_q    (cs_q),
    .odt_q   (odt_q),
    .cke_q   (cke_q)
  );

  csrb_fanout #(.DATA_W(DATA_W), .BANKS(BANKS)) u_fan (
    .dup_en    (dup_en),
    .word_q    (word_q),
    .cs_q      (cs_q),
    .odt_q     (odt_q),
    .cke_q     (cke_q),
    .bank_data (bank_data),
    .bank_cs   (bank_cs),
    .bank_odt  (bank_odt),
    .bank_cke  (bank_cke)
  );

  assign q_a    = bank_data[0];
  assign q_b    = bank_data[1];
  assign cs_a_n = bank_cs[0];
  assign cs_b_n = bank_cs[1];
  assign odt_a  = bank_odt[0];
  assign odt_b  = bank_odt[1];
  assign cke_a  = bank_cke[0];
  assign cke_b  = bank_cke[1];

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    !rst_n |-> (q_a == '0 && q_b == '0 && !cs_a_n && !cs_b_n &&
                !odt_a && !odt_b && !cke_a && !cke_b));

  // R6
  select_always_captured_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $past(rst_int_n) |-> (cs_a_n == $past(dcs_n)));

  // R7
  wide_bank_b_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_dup |-> (q_b == '0 && !cs_b_n && !odt_b && !cke_b));

  // R8
  narrow_banks_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_dup |-> (q_a == q_b && cs_a_n == cs_b_n && odt_a == odt_b &&
                  cke_a == cke_b && q_a[DATA_W-1:NARROW_W] == '0));

endmodule

// File: tb/tb_csrb_regbuf.sv
module tb_csrb_regbuf;

  localparam int DW = 23;
  localparam int NW = 11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b1;
  logic          mode_dup = 1'b0, mode_alt = 1'b0;
  logic          dcs_n = 1'b1, csr_n = 1'b1;
  logic [DW-1:0] din = '0;
  logic          odt_in = 1'b0, cke_in = 1'b0;
  logic [DW-1:0] q_a, q_b;
  logic          cs_a_n, cs_b_n, odt_a, odt_b, cke_a, cke_b;

  int    n_checks = 0;
  int    n_fails  = 0;
  string phase_tag = "";

  // reference model state
  logic [DW-1:0] m_word = '0;
  logic          m_cs = 1'b0, m_odt = 1'b0, m_cke = 1'b0;
  logic          m_held = 1'b0;
  int            m_rel = 0;

  always #10 clk = ~clk;

  csrb_regbuf dut (
    .clk(clk), .rst_n(rst_n), .mode_dup(mode_dup), .mode_alt(mode_alt),
    .dcs_n(dcs_n), .csr_n(csr_n), .din(din), .odt_in(odt_in), .cke_in(cke_in),
    .q_a(q_a), .q_b(q_b), .cs_a_n(cs_a_n), .cs_b_n(cs_b_n),
    .odt_a(odt_a), .odt_b(odt_b), .cke_a(cke_a), .cke_b(cke_b)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_word = '0; m_cs = 1'b0; m_odt = 1'b0; m_cke = 1'b0;
      m_held = 1'b0; m_rel = 0;
    end else if (m_rel < 2) begin
      m_rel = m_rel + 1;
    end else begin
      m_cs  = dcs_n;
      m_odt = odt_in;
      m_cke = cke_in;
      m_held = dcs_n && csr_n;
      if (!m_held) begin
        if (!mode_dup)     m_word = din;
        else if (mode_alt) m_word = DW'(din[2*NW-1:NW]);
        else               m_word = DW'(din[NW-1:0]);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string pick(input string tag);
    return (phase_tag != "") ? phase_tag : tag;
  endfunction

  task automatic compare_all();
    logic [DW-1:0] exp_b;
    string btag;
    exp_b = mode_dup ? m_word : '0;
    if (!mode_dup) btag = mode_alt ? "R10" : "R7";
    else           btag = mode_alt ? "R9" : "R8";
    chk(pick(m_held ? "R3" : "R4"), 32'(q_a), 32'(m_word));
    chk(pick(btag), 32'(q_b), 32'(exp_b));
    chk(pick("R6"), 32'(cs_a_n), 32'(m_cs));
    chk(pick("R6"), 32'(cs_b_n), 32'(mode_dup & m_cs));
    chk(pick("R5"), 32'({odt_a, cke_a}), 32'({m_odt, m_cke}));
    chk(pick("R5"), 32'({odt_b, cke_b}), 32'({mode_dup & m_odt, mode_dup & m_cke}));
  endtask

  task automatic drive_random(input bit csr_tied);
    din    = DW'($urandom);
    dcs_n  = 1'($urandom);
    csr_n  = csr_tied ? 1'b0 : 1'($urandom);
    odt_in = 1'($urandom);
    cke_in = 1'($urandom);
  endtask

  task automatic run_cycles(input int n, input bit csr_tied);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_all();
      drive_random(csr_tied);
    end
  endtask

  // async reset mid-cycle, reconfigure, release and walk the release window
  task automatic reset_into(input logic dup, input logic alt);
    @(negedge clk);
    #3 rst_n = 1'b0;
    #1;
    chk("R1", 32'(q_a), 32'd0);
    chk("R1", 32'({cs_a_n, odt_a, cke_a, cs_b_n, odt_b, cke_b}), 32'd0);
    mode_dup = dup;
    mode_alt = alt;
    phase_tag = "R1";
    run_cycles(3, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    din = DW'($urandom) | DW'(1);
    dcs_n = 1'b0;
    phase_tag = "R2";
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      compare_all();
    end
    phase_tag = "";
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    #1 rst_n = 1'b0;
    phase_tag = "R1";
    run_cycles(4, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    din = DW'(23'h5A5A5A);
    dcs_n = 1'b0; csr_n = 1'b1; odt_in = 1'b1; cke_in = 1'b1;
    phase_tag = "R2";
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      compare_all();
    end
    // R2: third edge after release is the first load
    chk("R2", 32'(q_a), 32'h5A5A5A);
    phase_tag = "";
    run_cycles(60, 1'b0);       // R3 R4 R5 R6 R7 wide mode
    reset_into(1'b0, 1'b1);     // R10 illegal pair
    run_cycles(40, 1'b0);
    reset_into(1'b1, 1'b0);     // R8 layout A
    run_cycles(60, 1'b0);
    reset_into(1'b1, 1'b1);     // R9 layout B
    run_cycles(60, 1'b0);
    reset_into(1'b0, 1'b0);     // R4 secondary select tied low
    run_cycles(40, 1'b1);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

endmodule